// File: doc/BRIEF.md
# Pipelined Fixed-Point Complex Multiplier

This block multiplies two complex numbers whose real and imaginary parts are signed fixed-point fractions: one sign bit followed by W-1 fraction bits, W = 8 by default. Each of the four partial products is first cut back to W bits, by truncation or by rounding. A subtract then forms the real part and an add forms the imaginary part. Both results are W+1 bits wide, so the combining stage can never overflow and needs no rounding of its own.

A sample is presented with `in_valid` high, together with a per-sample `round_en` select. The select applies to all four reductions of that sample. The pipeline has three register stages (multiply, reduce, combine) and never stalls. A new sample may enter on every cycle, and its result appears three cycles later with `out_valid` high.

Top module: `cmul_fixed`

## Requirements
- R1: `out_valid` equals the `in_valid` value sampled three clock edges earlier; a result appears exactly three cycles after its operands are sampled.
- R2: `p_re` equals red(a_re·b_re) − red(a_im·b_im), as a signed W+1-bit value.
- R3: `p_im` equals red(a_re·b_im) + red(a_im·b_re), as a signed W+1-bit value.
- R4: With `round_en` = 0, red(p) keeps bits [2W-2:W-1] of the 2W-bit product. This equals floor(p / 2^(W-1)), which is truncation toward minus infinity.
- R5: With `round_en` = 1, red(p) adds 2^(W-2) to the product before dropping the low W-1 bits. This equals floor((p + 2^(W-2)) / 2^(W-1)).
- R6: The product (−1)·(−1), raw value 2^(2W-2), reduces to the largest positive W-bit code 2^(W-1)−1 in both modes.
- R7: While `rst_n` is low, `out_valid`, `p_re` and `p_im` are all 0.
- R8: `round_en` is captured with its own sample's operands. Changing it on every cycle affects only the sample presented in that same cycle.
- R9: The results never wrap, including for full-scale operands. Results such as +254 and −254 (for W = 8) come out exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle form a sample |
| round_en | input | 1 | 1 = round the partial products, 0 = truncate them |
| a_re | input | W | Real part of operand A, signed fraction |
| a_im | input | W | Imaginary part of operand A |
| b_re | input | W | Real part of operand B |
| b_im | input | W | Imaginary part of operand B |
| out_valid | output | 1 | Result on `p_re`/`p_im` is valid |
| p_re | output | W+1 | Real part of the product |
| p_im | output | W+1 | Imaginary part of the product |

## Verification
On every cycle, the assertions check three things. Each reduced lane falls within one output step of the biased product. The (−1)·(−1) lane saturates. The combine stage forms exact differences and sums of its registered inputs, and the valid flag has a three-cycle latency. Some behaviours are visible only end to end in the bench scenarios. These are the per-sample alignment of the round select with its operands, and the signs and values of full-scale corner results. So is the choice of which partial products are paired for the real part and which for the imaginary part.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
   // Lane order of the four partial products
   typedef enum logic [1:0] {
      LN_RR = 2'd0,   // a_re * b_re
      LN_II = 2'd1,   // a_im * b_im
      LN_RI = 2'd2,   // a_re * b_im
      LN_IR = 2'd3    // a_im * b_re
   } lane_e;

   localparam int NLANES = 4;
   localparam int PIPE_DEPTH = 3;
endpackage

// File: rtl/cmul_lane_mul.sv
module cmul_lane_mul #(
   parameter int W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [W-1:0]   op_a,
   input  logic signed [W-1:0]   op_b,
   output logic signed [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= PW'(op_a) * PW'(op_b);
   end
endmodule

// File: rtl/cmul_reduce.sv
module cmul_reduce #(
   parameter int W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [2*W-1:0] prod,
   input  logic                  rnd,
   output logic signed [W-1:0]   red
);
   localparam int PW = 2 * W;
   localparam int SW = PW + 1;
   localparam int STEP = 1 << (W - 1);
   localparam logic signed [SW-1:0] BIAS = SW'(1 << (W - 2));
   localparam logic signed [W-1:0] MAXC = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] MINC = {1'b1, {(W-1){1'b0}}};
   localparam logic signed [PW-1:0] CORNER = {2'b01, {(PW-2){1'b0}}};

   if (W < 3) begin : g_bad_w
      $error("cmul_reduce: W must be at least 3");
   end

   logic signed [SW-1:0] sum_w;
   logic [2:0]           top3;
   logic                 sat;
   logic signed [W-1:0]  nxt;

   assign sum_w = {prod[PW-1], prod} + (rnd ? BIAS : '0);
   assign top3  = sum_w[SW-1:PW-2];
   assign sat   = !(top3 == 3'b000 || top3 == 3'b111);

   always_comb begin
      if (!sat)              nxt = sum_w[PW-2:W-1];
      else if (!sum_w[SW-1]) nxt = MAXC;
      else                   nxt = MINC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) red <= '0;
      else        red <= nxt;
   end

   // R4 R5: unsaturated lane lies within one step below the biased product
   reduce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sat)) |->
         (int'($past(sum_w)) >= int'(red) * STEP &&
          int'($past(sum_w)) <  int'(red) * STEP + STEP));

   // R6
   corner_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(prod) == CORNER) |-> red == MAXC);
endmodule

// File: rtl/cmul_combine.sv
module cmul_combine #(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] rr,
   input  logic signed [W-1:0] ii,
   input  logic signed [W-1:0] ri,
   input  logic signed [W-1:0] ir,
   output logic signed [W:0]   res_re,
   output logic signed [W:0]   res_im
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_re <= '0;
         res_im <= '0;
      end else begin
         res_re <= {rr[W-1], rr} - {ii[W-1], ii};
         res_im <= {ri[W-1], ri} + {ir[W-1], ir};
      end
   end

   // R2 R9
   re_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> int'(res_re) == int'($past(rr)) - int'($past(ii)));

   // R3 R9
   im_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> int'(res_im) == int'($past(ri)) + int'($past(ir)));
endmodule

// File: rtl/cmul_fixed.sv
module cmul_fixed
   import cmul_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                round_en,
   input  logic signed [W-1:0] a_re,
   input  logic signed [W-1:0] a_im,
   input  logic signed [W-1:0] b_re,
   input  logic signed [W-1:0] b_im,
   output logic                out_valid,
   output logic signed [W:0]   p_re,
   output logic signed [W:0]   p_im
);
   if (W < 3 || W > 15) begin : g_bad_w
      $error("cmul_fixed: W out of supported range 3..15");
   end

   logic signed [W-1:0]   opa   [NLANES];
   logic signed [W-1:0]   opb   [NLANES];
   logic signed [2*W-1:0] prods [NLANES];
   logic signed [W-1:0]   reds  [NLANES];
   logic                  v1, v2, rnd1;

   assign opa[LN_RR] = a_re;  assign opb[LN_RR] = b_re;
   assign opa[LN_II] = a_im;  assign opb[LN_II] = b_im;
   assign opa[LN_RI] = a_re;  assign opb[LN_RI] = b_im;
   assign opa[LN_IR] = a_im;  assign opb[LN_IR] = b_re;

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      cmul_lane_mul #(.W(W)) i_mul (
         .clk(clk), .rst_n(rst_n),
         .op_a(opa[g]), .op_b(opb[g]), .prod(prods[g]));
      cmul_reduce #(.W(W)) i_red (
         .clk(clk), .rst_n(rst_n),
         .prod(prods[g]), .rnd(rnd1), .red(reds[g]));
   end

   cmul_combine #(.W(W)) i_comb (
      .clk(clk), .rst_n(rst_n),
      .rr(reds[LN_RR]), .ii(reds[LN_II]),
      .ri(reds[LN_RI]), .ir(reds[LN_IR]),
      .res_re(p_re), .res_im(p_im));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1        <= 1'b0;
         v2        <= 1'b0;
         out_valid <= 1'b0;
         rnd1      <= 1'b0;
      end else begin
         v1        <= in_valid;
         v2        <= v1;
         out_valid <= v2;
         rnd1      <= round_en;
      end
   end

   // cycles since reset, saturating, for the latency check
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      age <= '0;
      else if (age != 2'(PIPE_DEPTH))  age <= age + 2'd1;
   end

   // R1
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'(PIPE_DEPTH)) |-> out_valid == $past(in_valid, 3));

   // R7
   reset_out_chk: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && p_re == '0 && p_im == '0));
endmodule

// File: tb/test_cmul_fixed.sv
module test_cmul_fixed;
   localparam int W = 8;
   localparam time PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, round_en = 1'b0;
   logic signed [W-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
   logic out_valid;
   logic signed [W:0] p_re, p_im;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   typedef struct { bit v; int re; int im; string tag; } exp_t;
   exp_t q[$];

   cmul_fixed #(.W(W)) i_cmul_fixed (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .round_en(round_en),
      .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .out_valid(out_valid), .p_re(p_re), .p_im(p_im));

   always #(PERIOD/2) clk = ~clk;

   // reduction to W bits per R4/R5/R6
   function automatic int red(int x, int y, bit r);
      int s, o;
      s = x * y + (r ? (1 << (W-2)) : 0);
      o = s >>> (W-1);
      if (o > (1 << (W-1)) - 1) o = (1 << (W-1)) - 1;
      return o;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a falling edge: compare the result due now, then drive
   task automatic step(bit v, bit r, int ar, int ai, int br, int bi, string tag);
      exp_t e, o;
      if (q.size() == 3) begin
         o = q.pop_front();
         chk({o.tag, " R1 valid"}, int'(out_valid), int'(o.v));
         if (o.v) begin
            chk({o.tag, " R2 real"}, int'(p_re), o.re);
            chk({o.tag, " R3 imag"}, int'(p_im), o.im);
         end
      end
      in_valid = v; round_en = r;
      a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
      e.v = v; e.tag = tag;
      e.re = red(ar, br, r) - red(ai, bi, r);
      e.im = red(ar, bi, r) + red(ai, br, r);
      q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: outputs held at zero in reset
      chk("R7 valid", int'(out_valid), 0);
      chk("R7 re", int'(p_re), 0);
      chk("R7 im", int'(p_im), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         exp_t z; z.v = 0; z.re = 0; z.im = 0; z.tag = "R1 idle"; q.push_back(z);
      end
      // R4: truncation floors negatives (-1*1 -> -1)
      step(1, 0, -1, 0, 1, 0, "R4 trunc");
      step(1, 0, 37, -90, 101, 55, "R4 trunc mix");
      // R5: rounding of the same values
      step(1, 1, 37, -90, 101, 55, "R5 round mix");
      step(1, 1, 64, 64, 1, 1, "R5 half step");
      // R6: (-1)*(-1) saturates, both modes
      step(1, 0, -128, 0, -128, 0, "R6 sat trunc");
      step(1, 1, -128, 0, -128, 0, "R6 sat round");
      // R9: full-scale extremes
      step(1, 0, -128, 127, -128, -128, "R9 max re");
      step(1, 0, -128, -128, 127, -128, "R9 min re");
      step(1, 1, -128, -128, -128, -128, "R9 all min");
      // R1: bubbles in the stream
      step(0, 0, 5, 5, 5, 5, "R1 bubble");
      step(1, 0, 3, -4, 5, -6, "R1 after bubble");
      step(0, 1, 0, 0, 0, 0, "R1 bubble2");
      // R8: round select toggled every cycle on identical operands
      for (int k = 0; k < 40; k++)
         step(1, k[0], 85, -43, -77, 99, "R8 toggle");
      // R2 R3: varied operands and modes
      for (int k = 0; k < 400; k++)
         step(($urandom % 5) != 0, $urandom % 2,
              int'($signed(8'($urandom))), int'($signed(8'($urandom))),
              int'($signed(8'($urandom))), int'($signed(8'($urandom))),
              "R2R3 mixed");
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, "R1 drain");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule